// File: doc/BRIEF.md
# SIMD Lane Divergence Mask Stack

This block steers a group of rays that run in lockstep on a SIMD datapath. Every lane executes the same instruction. The block holds the active-lane mask, which decides whose results are kept. When a conditional branch gets different answers from different active lanes, the group splits in two:

- The lanes that take the branch keep running under a narrowed mask.
- The other lanes are parked on a hardware stack, together with the address at which they resume.

A reconverge command brings the parked lanes back in last-in-first-out order. When nothing is parked, the command restores the full mask captured when the group was launched. Nesting works down to a single live lane, where execution is fully serial.

The surrounding sequencer supplies the current PC, per-lane condition bits, a branch target and the reconverge strobe. It uses the registered active mask and next PC on the following cycle.

Top module: `simd_mask_stack`

## Requirements
- R1: After a synchronous reset, act_mask is 0, next_pc is 0, stk_empty is 1 and ovf_err is 0.
- R2: A launch (start_valid with a nonzero start_mask) sets act_mask to start_mask and next_pc to start_pc. It also records start_mask as the full mask, empties the stack and clears ovf_err. A launch whose start_mask is all zeros changes nothing.
- R3: While act_mask is 0 (no group launched), branch and reconverge commands leave every output unchanged.
- R4: On a branch where every active lane has its br_cond bit at 1 (bit i belongs to lane i, 1 means taken), act_mask stays the same, next_pc becomes br_target and nothing is pushed.
- R5: On a branch where every active lane has its br_cond bit at 0, act_mask stays the same, next_pc becomes cur_pc+1 and nothing is pushed.
- R6: On a branch where active lanes disagree, act_mask becomes the active lanes with br_cond 1 and next_pc becomes br_target. The entry pushed holds the active lanes with br_cond 0 and the resume address cur_pc+1, and stk_empty falls.
- R7: A reconverge with a nonempty stack pops the most recently pushed entry. Its lane mask becomes act_mask and its resume address becomes next_pc.
- R8: A reconverge with an empty stack sets act_mask to the full mask recorded at launch and next_pc to cur_pc+1.
- R9: In a cycle with no command while a group is live, act_mask holds and next_pc becomes cur_pc+1.
- R10: A diverging branch while the stack already holds DEPTH entries sets ovf_err, pushes nothing, and still narrows act_mask to the taken lanes with next_pc = br_target. ovf_err stays set until the next launch or reset.
- R11: When several commands arrive in one cycle, launch wins over branch, and branch wins over reconverge.
- R12: Once a group is launched, act_mask never returns to all zeros before the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Launch a new lane group |
| start_mask | input | LANES | Lanes present in the new group |
| start_pc | input | PC_W | First instruction address of the group |
| br_valid | input | 1 | Conditional branch command |
| br_cond | input | LANES | Per-lane branch outcome, 1 = taken |
| br_target | input | PC_W | Branch destination |
| rc_valid | input | 1 | Reconverge / pop command |
| cur_pc | input | PC_W | Address of the instruction now issuing |
| act_mask | output | LANES | Registered active-lane mask |
| next_pc | output | PC_W | Registered next instruction address |
| stk_empty | output | 1 | No parked sub-group on the stack |
| ovf_err | output | 1 | Sticky stack overflow flag |

## Verification
The bench drives two copies of the block with the same stimulus. One uses the default build of 4 lanes and 8 entries. The other uses 4 lanes and only 2 entries. With four lanes the parked masks are disjoint, so at most three entries can ever be pending. Overflow is therefore unreachable at depth 8, and only the shallow copy reaches the R10 path. The deep copy shows the full three-level nest down to one lane and its LIFO unwinding.

// File: rtl/simd_mask_pkg.sv
package simd_mask_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_LAUNCH = 2'd1,
    CMD_BRANCH = 2'd2,
    CMD_RECONV = 2'd3
  } mask_cmd_e;
endpackage

// File: rtl/mask_branch_eval.sv
module mask_branch_eval #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] act,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] taken_mask,
  output logic [LANES-1:0] other_mask,
  output logic             all_take,
  output logic             none_take,
  output logic             split
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign taken_mask[g] = act[g] & cond[g];
    assign other_mask[g] = act[g] & ~cond[g];
  end

  always_comb begin
    all_take  = (other_mask == '0);
    none_take = (taken_mask == '0) && !all_take;
    split     = !all_take && !none_take;
  end
endmodule

// File: rtl/mask_stack_mem.sv
module mask_stack_mem #(
  parameter int DEPTH = 8,
  parameter int W     = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int SP_W = $clog2(DEPTH + 1);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] sp_top;

  assign sp_top = sp - SP_W'(1);
  assign empty  = (sp == '0);
  assign full   = (sp == SP_W'(DEPTH));
  assign rdata  = mem[sp_top[AW-1:0]];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[sp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)          sp <= '0;
    else if (push && !full)  sp <= sp + SP_W'(1);
    else if (pop && !empty)  sp <= sp - SP_W'(1);
  end
endmodule

// File: rtl/simd_mask_stack.sv
module simd_mask_stack
  import simd_mask_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int PC_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_valid,
  input  logic [LANES-1:0] start_mask,
  input  logic [PC_W-1:0]  start_pc,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_cond,
  input  logic [PC_W-1:0]  br_target,
  input  logic             rc_valid,
  input  logic [PC_W-1:0]  cur_pc,
  output logic [LANES-1:0] act_mask,
  output logic [PC_W-1:0]  next_pc,
  output logic             stk_empty,
  output logic             ovf_err
);
  localparam int ENT_W = LANES + PC_W;

  logic [LANES-1:0] mask_q, full_q;
  logic [PC_W-1:0]  pc_q;
  logic             err_q;
  logic             live;
  logic [PC_W-1:0]  pc_inc;
  mask_cmd_e        cmd;

  logic [LANES-1:0] tk_mask, nt_mask;
  logic             all_take, none_take, split;
  logic             st_push, st_pop, st_clr, st_empty, st_full;
  logic [ENT_W-1:0] st_wdata, st_rdata;

  assign live   = (mask_q != '0);
  assign pc_inc = cur_pc + PC_W'(1);

  always_comb begin
    if (start_valid && (start_mask != '0)) cmd = CMD_LAUNCH;
    else if (live && br_valid)             cmd = CMD_BRANCH;
    else if (live && rc_valid)             cmd = CMD_RECONV;
    else                                   cmd = CMD_IDLE;
  end

  mask_branch_eval #(.LANES(LANES)) i_eval (
    .act        (mask_q),
    .cond       (br_cond),
    .taken_mask (tk_mask),
    .other_mask (nt_mask),
    .all_take   (all_take),
    .none_take  (none_take),
    .split      (split)
  );

  assign st_clr   = (cmd == CMD_LAUNCH);
  assign st_push  = (cmd == CMD_BRANCH) && split;
  assign st_pop   = (cmd == CMD_RECONV);
  assign st_wdata = {nt_mask, pc_inc};

  mask_stack_mem #(.DEPTH(DEPTH), .W(ENT_W)) i_stack (
    .clk   (clk),
    .rst   (rst),
    .clr   (st_clr),
    .push  (st_push),
    .pop   (st_pop),
    .wdata (st_wdata),
    .rdata (st_rdata),
    .empty (st_empty),
    .full  (st_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      full_q <= '0;
      pc_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_LAUNCH: begin
          mask_q <= start_mask;
          full_q <= start_mask;
          pc_q   <= start_pc;
          err_q  <= 1'b0;
        end
        CMD_BRANCH: begin
          if (all_take)       pc_q <= br_target;
          else if (none_take) pc_q <= pc_inc;
          else begin
            mask_q <= tk_mask;
            pc_q   <= br_target;
            if (st_full) err_q <= 1'b1;
          end
        end
        CMD_RECONV: begin
          if (!st_empty) begin
            mask_q <= st_rdata[ENT_W-1:PC_W];
            pc_q   <= st_rdata[PC_W-1:0];
          end else begin
            mask_q <= full_q;
            pc_q   <= pc_inc;
          end
        end
        default: begin
          if (live) pc_q <= pc_inc;
        end
      endcase
    end
  end

  assign act_mask  = mask_q;
  assign next_pc   = pc_q;
  assign stk_empty = st_empty;
  assign ovf_err   = err_q;
endmodule

// File: rtl/simd_mask_stack_chk.sv
module simd_mask_stack_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_valid,
  input logic [LANES-1:0] start_mask,
  input logic             br_valid,
  input logic [LANES-1:0] br_cond,
  input logic             rc_valid,
  input logic [LANES-1:0] act_mask,
  input logic             stk_empty,
  input logic             ovf_err
);
  logic launch;
  assign launch = start_valid && (start_mask != '0);

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (act_mask == '0) && stk_empty && !ovf_err);

  p_idle_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    (act_mask == '0) && !launch |=> (act_mask == '0) && stk_empty);

  p_split_push_r6: assert property (@(posedge clk) disable iff (rst)
    !launch && br_valid && ((act_mask & br_cond) != '0) &&
    ((act_mask & ~br_cond) != '0) |=> !stk_empty);

  p_hold_mask_r9: assert property (@(posedge clk) disable iff (rst)
    !launch && !br_valid && !rc_valid |=> $stable(act_mask));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    ovf_err && !launch |=> ovf_err);

  p_never_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (act_mask != '0) |=> (act_mask != '0));
endmodule

bind simd_mask_stack simd_mask_stack_chk #(.LANES(LANES)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .start_valid (start_valid),
  .start_mask  (start_mask),
  .br_valid    (br_valid),
  .br_cond     (br_cond),
  .rc_valid    (rc_valid),
  .act_mask    (act_mask),
  .stk_empty   (stk_empty),
  .ovf_err     (ovf_err)
);

// File: tb/test_simd_mask_stack.sv
module test_simd_mask_stack;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_valid = 1'b0;
  logic [3:0]  start_mask = '0;
  logic [15:0] start_pc = '0;
  logic        br_valid = 1'b0;
  logic [3:0]  br_cond = '0;
  logic [15:0] br_target = '0;
  logic        rc_valid = 1'b0;
  logic [15:0] cur_pc = '0;

  logic [3:0]  am [2];
  logic [15:0] np [2];
  logic        se [2];
  logic        oe [2];

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // reference state per copy: index 0 = depth 8, index 1 = depth 2
  logic [3:0]  m_mask [2];
  logic [3:0]  m_full [2];
  logic [15:0] m_pc [2];
  logic        m_err [2];
  int          m_sp [2];
  logic [3:0]  s_mask [2][8];
  logic [15:0] s_pc [2][8];
  int          m_depth [2] = '{8, 2};

  always #2 clk = ~clk;

  simd_mask_stack i_simd_mask_stack (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_mask(start_mask),
    .start_pc(start_pc), .br_valid(br_valid), .br_cond(br_cond),
    .br_target(br_target), .rc_valid(rc_valid), .cur_pc(cur_pc),
    .act_mask(am[0]), .next_pc(np[0]), .stk_empty(se[0]), .ovf_err(oe[0]));

  simd_mask_stack #(.DEPTH(2)) i_simd_mask_stack_small (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_mask(start_mask),
    .start_pc(start_pc), .br_valid(br_valid), .br_cond(br_cond),
    .br_target(br_target), .rc_valid(rc_valid), .cur_pc(cur_pc),
    .act_mask(am[1]), .next_pc(np[1]), .stk_empty(se[1]), .ovf_err(oe[1]));

  task automatic model_update();
    for (int k = 0; k < 2; k++) begin
      logic [3:0] tk, nt;
      tk = m_mask[k] & br_cond;
      nt = m_mask[k] & ~br_cond;
      if (rst) begin
        m_mask[k] = '0; m_full[k] = '0; m_pc[k] = '0; m_err[k] = 1'b0; m_sp[k] = 0;
      end else if (start_valid && start_mask != 4'd0) begin
        m_mask[k] = start_mask; m_full[k] = start_mask; m_pc[k] = start_pc;
        m_err[k] = 1'b0; m_sp[k] = 0;
      end else if (m_mask[k] != 4'd0 && br_valid) begin
        if (nt == 4'd0) m_pc[k] = br_target;
        else if (tk == 4'd0) m_pc[k] = cur_pc + 16'd1;
        else begin
          if (m_sp[k] < m_depth[k]) begin
            s_mask[k][m_sp[k]] = nt;
            s_pc[k][m_sp[k]] = cur_pc + 16'd1;
            m_sp[k]++;
          end else m_err[k] = 1'b1;
          m_mask[k] = tk;
          m_pc[k] = br_target;
        end
      end else if (m_mask[k] != 4'd0 && rc_valid) begin
        if (m_sp[k] > 0) begin
          m_sp[k]--;
          m_mask[k] = s_mask[k][m_sp[k]];
          m_pc[k] = s_pc[k][m_sp[k]];
        end else begin
          m_mask[k] = m_full[k];
          m_pc[k] = cur_pc + 16'd1;
        end
      end else if (m_mask[k] != 4'd0) m_pc[k] = cur_pc + 16'd1;
    end
  endtask

  task automatic compare();
    for (int k = 0; k < 2; k++) begin
      total++;
      if (am[k] !== m_mask[k] || np[k] !== m_pc[k] ||
          se[k] !== (m_sp[k] == 0) || oe[k] !== m_err[k]) begin
        bad++;
        $display("FAIL %s copy%0d: actual mask=%b pc=%h empty=%b err=%b expected mask=%b pc=%h empty=%b err=%b",
                 tag, k, am[k], np[k], se[k], oe[k], m_mask[k], m_pc[k], (m_sp[k] == 0), m_err[k]);
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    #1;
    compare();
    @(negedge clk);
    start_valid = 1'b0; br_valid = 1'b0; rc_valid = 1'b0;
  endtask

  task automatic do_branch(input logic [3:0] c, input logic [15:0] tgt, input logic [15:0] pc);
    br_valid = 1'b1; br_cond = c; br_target = tgt; cur_pc = pc; step();
  endtask

  task automatic do_reconv(input logic [15:0] pc);
    rc_valid = 1'b1; cur_pc = pc; step();
  endtask

  task automatic do_start(input logic [3:0] m, input logic [15:0] pc);
    start_valid = 1'b1; start_mask = m; start_pc = pc; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lfsr;
    @(negedge clk);
    tag = "R1"; step(); step();
    rst = 1'b0; step();
    tag = "R3"; do_branch(4'b0101, 16'h0050, 16'h0010); do_reconv(16'h0011);
    tag = "R2"; do_start(4'b0000, 16'h0777);
    do_start(4'b1111, 16'h0100);
    tag = "R9"; cur_pc = 16'h0100; step(); cur_pc = 16'h0101; step();
    tag = "R4"; do_branch(4'b1111, 16'h0180, 16'h0102);
    tag = "R5"; do_branch(4'b0000, 16'h01a0, 16'h0180);
    tag = "R6"; do_branch(4'b0111, 16'h0200, 16'h0120);
    do_branch(4'b1011, 16'h0300, 16'h0200);
    tag = "R10"; do_branch(4'b1001, 16'h0400, 16'h0300);
    tag = "R9"; cur_pc = 16'h0400; step();
    tag = "R7"; do_reconv(16'h0401); do_reconv(16'h0302); do_reconv(16'h0202);
    tag = "R8"; do_reconv(16'h0500);
    tag = "R11";
    start_valid = 1'b1; start_mask = 4'b0110; start_pc = 16'h0600;
    br_valid = 1'b1; br_cond = 4'b0010; rc_valid = 1'b1; step();
    br_valid = 1'b1; br_cond = 4'b0100; br_target = 16'h0700; rc_valid = 1'b1;
    cur_pc = 16'h0600; step();
    tag = "R2"; do_start(4'b1111, 16'h0800);
    tag = "R12";
    lfsr = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cur_pc = lfsr[27:12];
      if (lfsr[7:3] == 5'd0) begin
        start_valid = 1'b1; start_mask = lfsr[11:8]; start_pc = lfsr[31:16];
      end
      br_valid = lfsr[0] ^ lfsr[9];
      br_cond = lfsr[15:12];
      br_target = lfsr[31:16] ^ 16'h00f0;
      rc_valid = lfsr[2] & lfsr[5];
      step();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule